// File: doc/BRIEF.md
# Memory-Mapped Keyboard Input Port

This block is a single-character input device that sits on a 16-bit memory-mapped bus. A keyboard-side source offers one 8-bit ASCII code at a time with a valid strobe. The port latches one code and raises a ready flag. It will not accept another code until software has taken the one it holds. Software can poll the ready flag through a status word. It can also set an enable bit so that the port raises a level interrupt request while a character is waiting.

The bus side decodes two fixed word addresses: one for status and one for the held character. Reads complete in the same cycle they are presented. Reading the character word is the act that frees the port: ready clears and the keyboard side is accepted again. A code that arrives while the port is still full is thrown away, because there is no queue.

Top module: `kbd_input_port`

## Requirements
- R1: A read (bus_sel=1, bus_we=0) returns the result in the same cycle. At address 16'hFE00 it returns ready in bit 15, interrupt enable in bit 14 and zero in every other bit. At 16'hFE02 it returns the held code in bits [7:0] and zero in bits [15:8]. Any other address, and any cycle that is not a read, returns zero.
- R2: With ready at 0, a cycle with key_valid=1 sets ready and stores key_char, and both are visible from the next cycle on.
- R3: With ready at 1, and no read of 16'hFE02 in the same cycle, key_valid is ignored: the held code and ready do not change.
- R4: A read of 16'hFE02 returns the held code and clears ready at the next edge. After that, the next arriving code is accepted.
- R5: A write (bus_sel=1, bus_we=1) to 16'hFE00 loads bus_wdata[14] into the enable bit and leaves ready unchanged. Writes to any other address, including 16'hFE02, change nothing.
- R6: irq_o is registered. It is 1 in the cycle after a cycle in which ready and enable were both 1, and 0 in the cycle after either one was 0.
- R7: When a code arrives in the same cycle that 16'hFE02 is read, the read returns the old code, the new code is stored, and ready stays 1.
- R8: Reset (rst_n=0) clears ready, enable, the held code and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| key_valid | input | 1 | Keyboard offers a code this cycle |
| key_char | input | 8 | ASCII code offered |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench targets the cycle where a read of the character word coincides with a new arrival. A design that prioritised the clear would lose the new code and drop ready. A design that captured early would return the new code on the bus. Arrivals that land while the port is full are driven repeatedly. A design that queued or overwrote would show a changed code on the next read. Status writes carry random patterns in every bit, so a design that let a write disturb ready or the zero bits would show it on readback. The interrupt is checked on every cycle against a one-cycle-delayed model, which catches an unregistered request or one that lingers after ready clears.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
    localparam int KP_WORD_W   = 16;
    localparam int KP_CHAR_W   = 8;
    localparam logic [15:0] KP_STATUS_ADDR = 16'hFE00;
    localparam logic [15:0] KP_DATA_ADDR   = 16'hFE02;
    localparam int KP_READY_BIT = 15;
    localparam int KP_IE_BIT    = 14;
endpackage

// File: rtl/kbd_bus_decode.sv
module kbd_bus_decode
    import kbd_port_pkg::*;
#(
    parameter int ADDR_W = KP_WORD_W,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = KP_STATUS_ADDR,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = KP_DATA_ADDR
) (
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rd_status_o,
    output logic              rd_data_o,
    output logic              wr_status_o
);
    logic hit_status, hit_data;

    always_comb begin
        hit_status  = (addr_i == STATUS_ADDR);
        hit_data    = (addr_i == DATA_ADDR);
        rd_status_o = sel_i && !we_i && hit_status;
        rd_data_o   = sel_i && !we_i && hit_data;
        wr_status_o = sel_i &&  we_i && hit_status;
    end
endmodule

// File: rtl/kbd_char_holder.sv
module kbd_char_holder
    import kbd_port_pkg::*;
#(
    parameter int CHAR_W = KP_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid_i,
    input  logic [CHAR_W-1:0] key_char_i,
    input  logic              take_i,
    output logic              ready_o,
    output logic [CHAR_W-1:0] char_o
);
    typedef struct packed {
        logic              ready;
        logic [CHAR_W-1:0] ch;
    } hold_t;

    hold_t st_d, st_q;
    logic  accept;

    always_comb begin
        st_d   = st_q;
        accept = key_valid_i && (!st_q.ready || take_i);
        if (accept) begin
            st_d.ready = 1'b1;
            st_d.ch    = key_char_i;
        end else if (take_i) begin
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = st_q.ready;
    assign char_o  = st_q.ch;

    // R2: an idle port captures an offered code
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid_i && !ready_o) |=> (ready_o && char_o == $past(key_char_i)));

    // R3: a full port drops arrivals and keeps its code
    a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !take_i) |=> (ready_o && $stable(char_o)));

    // R4: taking the code with no arrival frees the port
    a_r4_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !key_valid_i) |=> !ready_o);

    // R7: take and arrival together keep the port full with the new code
    a_r7_take_and_arrive: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && key_valid_i) |=> (ready_o && char_o == $past(key_char_i)));
endmodule

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ie_wr_i,
    input  logic ie_wbit_i,
    input  logic ready_i,
    output logic ie_o,
    output logic irq_o
);
    typedef struct packed {
        logic ie;
        logic irq;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.irq = ready_i && c_q.ie;
        if (ie_wr_i) c_d.ie = ie_wbit_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ie_o  = c_q.ie;
    assign irq_o = c_q.irq;

    // R6: request follows ready and enable one cycle later
    a_r6_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && ie_o) |=> irq_o);
    a_r6_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_i || !ie_o) |=> !irq_o);

    // R5: enable only moves on a status write
    a_r5_ie_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_wr_i |=> $stable(ie_o));
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
    import kbd_port_pkg::*;
#(
    parameter int WORD_W = KP_WORD_W,
    parameter int CHAR_W = KP_CHAR_W,
    parameter logic [WORD_W-1:0] STATUS_ADDR = KP_STATUS_ADDR,
    parameter logic [WORD_W-1:0] DATA_ADDR   = KP_DATA_ADDR,
    parameter int READY_BIT = KP_READY_BIT,
    parameter int IE_BIT    = KP_IE_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    output logic              irq_o
);
    logic              rd_status, rd_data, wr_status;
    logic              ready, ie;
    logic [CHAR_W-1:0] held;

    kbd_bus_decode #(
        .ADDR_W(WORD_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_decode (
        .sel_i(bus_sel), .we_i(bus_we), .addr_i(bus_addr),
        .rd_status_o(rd_status), .rd_data_o(rd_data), .wr_status_o(wr_status)
    );

    kbd_char_holder #(.CHAR_W(CHAR_W)) u_holder (
        .clk(clk), .rst_n(rst_n),
        .key_valid_i(key_valid), .key_char_i(key_char),
        .take_i(rd_data), .ready_o(ready), .char_o(held)
    );

    kbd_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n),
        .ie_wr_i(wr_status), .ie_wbit_i(bus_wdata[IE_BIT]),
        .ready_i(ready), .ie_o(ie), .irq_o(irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_status) begin
            bus_rdata[READY_BIT] = ready;
            bus_rdata[IE_BIT]    = ie;
        end else if (rd_data) begin
            bus_rdata[CHAR_W-1:0] = held;
        end
    end

    // R1: upper byte of the character word is always zero
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data |-> (bus_rdata[WORD_W-1:CHAR_W] == '0));

    // R1: non-read cycles drive zero
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || bus_we) |-> (bus_rdata == '0));
endmodule

// File: tb/test_kbd_input_port.sv
module test_kbd_input_port;
    localparam logic [15:0] A_ST = 16'hFE00;
    localparam logic [15:0] A_DT = 16'hFE02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        key_valid = 1'b0;
    logic [7:0]  key_char = '0;
    logic        irq_o;

    int n_checks = 0, n_fail = 0;
    logic       m_ready = 0, m_ie = 0, m_irq = 0;
    logic [7:0] m_char = 0;

    always #5 clk = ~clk;

    kbd_input_port i_kbd_input_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_valid(key_valid), .key_char(key_char), .irq_o(irq_o)
    );

    function automatic logic [15:0] exp_read(logic sel, logic we, logic [15:0] a);
        if (!sel || we) return 16'h0;
        if (a == A_ST) return {m_ready, m_ie, 14'h0};
        if (a == A_DT) return {8'h00, m_char};
        return 16'h0;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus/keyboard cycle; entered just after a falling edge
    task automatic step(logic sel, logic we, logic [15:0] a, logic [15:0] wd,
                        logic kv, logic [7:0] kc, string tag);
        logic rd, wr, cap;
        check({tag, " irq (R6)"}, {15'h0, irq_o}, {15'h0, m_irq});
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
        key_valid = kv; key_char = kc;
        #1;
        check({tag, " rdata"}, bus_rdata, exp_read(sel, we, a));
        rd  = sel && !we && (a == A_DT);
        wr  = sel && we && (a == A_ST);
        cap = kv && (!m_ready || rd);
        m_irq = m_ready && m_ie;
        if (wr) m_ie = wd[14];
        if (cap) begin m_ready = 1; m_char = kc; end
        else if (rd) m_ready = 0;
        @(negedge clk);
    endtask

    task automatic rd_st(string tag); step(1, 0, A_ST, 16'h0, 0, 8'h0, tag); endtask
    task automatic rd_dt(string tag); step(1, 0, A_DT, 16'h0, 0, 8'h0, tag); endtask
    task automatic key(logic [7:0] c, string tag); step(0, 0, 16'h0, 16'h0, 1, c, tag); endtask
    task automatic idle(string tag); step(0, 0, 16'h0, 16'h0, 0, 8'h0, tag); endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        rd_st("R8 reset status");
        rd_dt("R8 reset data");
        // R2: capture into an empty port
        key(8'h41, "R2 capture");
        rd_st("R2 ready set");
        // R3: arrivals while full are dropped
        key(8'h42, "R3 drop");
        key(8'h43, "R3 drop again");
        // R5: write status with all bits set, only enable moves
        step(1, 1, A_ST, 16'hFFFF, 0, 8'h0, "R5 write ie");
        rd_st("R5 status after write");
        step(1, 1, A_DT, 16'h00FF, 0, 8'h0, "R5 data write ignored");
        idle("R6 irq high");
        // R4: take the code, ready clears
        rd_dt("R4 take");
        rd_st("R4 ready cleared");
        idle("R6 irq low");
        key(8'h55, "R4 accept after take");
        // R7: take and arrival together
        step(1, 0, A_DT, 16'h0, 1, 8'h66, "R7 take and arrive");
        rd_st("R7 ready still set");
        rd_dt("R7 new code held");
        step(1, 1, A_ST, 16'hBFFF, 0, 8'h0, "R5 clear ie");
        key(8'h77, "R5 other address");
        step(1, 0, 16'hFE01, 16'h0, 0, 8'h0, "R1 unmapped read");
        rd_dt("R1 data read");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            int pick = $urandom_range(0, 3);
            a = (pick == 0) ? A_ST : (pick == 1) ? A_DT :
                (pick == 2) ? 16'hFE01 : 16'($urandom);
            step($urandom_range(0, 2) != 0, $urandom_range(0, 3) == 0, a,
                 16'($urandom), $urandom_range(0, 2) == 0, 8'($urandom), "random");
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_ready = 0; m_ie = 0; m_irq = 0; m_char = 0;
        rd_st("R8 second reset status");
        rd_dt("R8 second reset data");
        finish_run();
    end
endmodule